// File: doc/BRIEF.md
# Programmable Asynchronous Character Transmitter

This block is the sending side of a small asynchronous serial adapter. A host places a byte into a one-entry holding buffer. At the next bit boundary the block copies the byte into an internal shift register and sends it on a single serial line as one framed character. The frame is a low start bit, then the data bits starting with the least significant, then an optional parity bit, then one or two high stop bits. The line rests high whenever no character is in flight.

A 3-bit format code selects one of eight combined word-length, parity and stop-bit settings. A 2-bit rate code chooses how many pulses of an external transmit clock make up one bit time. The fourth rate code does not select a ratio: it holds the whole transmitter in master reset. The transmit clock enters as a one-cycle `tx_tick` enable that is sampled in the system clock domain. The host polls `hold_empty` before each write. The block also drives an active-low request-to-send line from a host control bit.

Top module: `async_char_tx`

## Requirements
- R1: The line idles at 1. Each character begins with one start bit at 0, sends its data bits least significant bit first, and ends with its stop bits at 1.
- R2: `fmt_sel` picks the frame: 000 = 7 data, even parity, 2 stop; 001 = 7 data, odd parity, 2 stop; 010 = 7 data, even parity, 1 stop; 011 = 7 data, odd parity, 1 stop; 100 = 8 data, no parity, 2 stop; 101 = 8 data, no parity, 1 stop; 110 = 8 data, even parity, 1 stop; 111 = 8 data, odd parity, 1 stop.
- R3: When parity is present, it sits right after the last data bit and before the stop bits. With even parity the count of ones across the data bits and the parity bit is even. With odd parity that count is odd.
- R4: In 7-bit formats, bit 7 of the written byte is neither sent nor counted in the parity.
- R5: One bit time lasts 1, 16 or 64 `tx_tick` pulses for `rate_sel` = 00, 01 or 10. The line changes only at the end of a bit time.
- R6: `hold_empty` is 1 after reset. A write (`wr_en` high while `hold_empty` is 1) stores `wr_data` and clears `hold_empty` on the next clock.
- R7: When a pending byte moves into the shift register, its start bit appears on `txd` and `hold_empty` returns to 1 on the same clock edge.
- R8: A write while `hold_empty` is 0 is ignored. The flag stays 0 and the byte already pending is the one sent.
- R9: If a byte is pending when the last stop bit ends, the next start bit begins at that same bit boundary, with no idle bit between the two characters.
- R10: `rate_sel` = 11 is master reset. On the next clock `txd` is 1 and `hold_empty` is 1. A character in flight is cut off, the pending byte is dropped, and writes during master reset are ignored.
- R11: `rts_n` is the inverse of `rts_on`. It is forced to 1 during master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_tick | input | 1 | One-cycle pulse per edge of the external transmit clock |
| fmt_sel | input | 3 | Frame format code |
| rate_sel | input | 2 | Bit-time ratio, or master reset for 11 |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| rts_on | input | 1 | Host request to assert request-to-send |
| txd | output | 1 | Serial data line |
| hold_empty | output | 1 | Holding buffer can take a byte |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
Every format code is tried with bytes chosen so that codes which share a word length differ only in parity sense or stop count. A byte with bit 7 set but an equal low-seven-bit pattern shows whether the top bit leaks into 7-bit frames. Bit times are measured for each ratio and for a sparse tick stream, which separates counting clock cycles from counting ticks. A write to a full buffer, a back-to-back pair and a master reset in the middle of a frame separate dropping a byte from overwriting it, a gap between characters from none, and a full abort from one that only stops the line.

// File: rtl/async_tx_pkg.sv
`timescale 1ns/1ps
package async_tx_pkg;

    localparam int WORD_W = 8;
    localparam int REST_W = WORD_W + 3;
    localparam int LEN_W  = 4;

    typedef struct packed {
        logic long_word;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_fmt_t;

    typedef enum logic [1:0] {
        RATE_ONE  = 2'b00,
        RATE_MID  = 2'b01,
        RATE_HI   = 2'b10,
        RATE_MRST = 2'b11
    } rate_code_t;

    function automatic frame_fmt_t decode_fmt(input logic [2:0] code);
        frame_fmt_t f;
        case (code)
            3'b000:  f = '{long_word: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b1};
            3'b001:  f = '{long_word: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b1};
            3'b010:  f = '{long_word: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
            3'b011:  f = '{long_word: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
            3'b100:  f = '{long_word: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b1};
            3'b101:  f = '{long_word: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
            3'b110:  f = '{long_word: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
            default: f = '{long_word: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/tx_frame_build.sv
`timescale 1ns/1ps
module tx_frame_build
    import async_tx_pkg::*;
(
    input  logic [2:0]        fmt_code,
    input  logic [WORD_W-1:0] byte_in,
    output logic [REST_W-1:0] rest_bits,
    output logic [LEN_W-1:0]  rest_len
);
    localparam int SHORT_W = WORD_W - 1;

    frame_fmt_t          fmt;
    logic [WORD_W-1:0]   used;
    logic                par_bit;
    logic [LEN_W-1:0]    n_data;

    always_comb begin
        fmt     = decode_fmt(fmt_code);
        used    = fmt.long_word ? byte_in : {1'b0, byte_in[SHORT_W-1:0]};
        n_data  = fmt.long_word ? LEN_W'(WORD_W) : LEN_W'(SHORT_W);
        par_bit = (^used) ^ fmt.par_odd;
        rest_bits = '1;
        for (int i = 0; i < WORD_W; i++) begin
            if (LEN_W'(i) < n_data) begin
                rest_bits[i] = used[i];
            end
        end
        if (fmt.par_en) begin
            rest_bits[n_data] = par_bit;
        end
        rest_len = n_data + LEN_W'(fmt.par_en) + (fmt.two_stop ? LEN_W'(2) : LEN_W'(1));
    end

endmodule

// File: rtl/tx_bit_timer.sv
`timescale 1ns/1ps
module tx_bit_timer
    import async_tx_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_tick,
    input  logic [1:0] rate_sel,
    output logic       bit_stb
);
    localparam int CNT_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t           tmr_d, tmr_q;
    logic [CNT_W-1:0] limit;
    logic             mrst;

    always_comb begin
        tmr_d   = tmr_q;
        bit_stb = 1'b0;
        mrst    = (rate_sel == RATE_MRST);
        limit   = (rate_sel == RATE_MID) ? CNT_W'(DIV_MID - 1) : CNT_W'(DIV_HI - 1);
        if (mrst) begin
            tmr_d.cnt = '0;
        end else if (tx_tick) begin
            if (rate_sel == RATE_ONE) begin
                bit_stb   = 1'b1;
                tmr_d.cnt = '0;
            end else if (tmr_q.cnt >= limit) begin
                bit_stb   = 1'b1;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && (rate_sel == RATE_MID || rate_sel == RATE_HI)) |=> (!bit_stb || rate_sel == RATE_ONE)); // R5

    AST_MRST_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == RATE_MRST) |-> !bit_stb); // R10

endmodule

// File: rtl/tx_char_shifter.sv
`timescale 1ns/1ps
module tx_char_shifter
    import async_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              mrst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [REST_W-1:0] frame_rest,
    input  logic [LEN_W-1:0]  frame_len,
    output logic [WORD_W-1:0] hold_byte,
    output logic              txd,
    output logic              hold_empty
);
    typedef struct packed {
        logic              busy;
        logic              txd;
        logic              empty;
        logic [WORD_W-1:0] hold;
        logic [REST_W-1:0] shreg;
        logic [LEN_W-1:0]  left;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mrst) begin
            st_d.busy  = 1'b0;
            st_d.txd   = 1'b1;
            st_d.empty = 1'b1;
            st_d.shreg = '0;
            st_d.left  = '0;
        end else begin
            if (wr_en && st_q.empty) begin
                st_d.hold  = wr_data;
                st_d.empty = 1'b0;
            end
            if (bit_stb) begin
                if (st_q.busy && st_q.left != '0) begin
                    st_d.txd   = st_q.shreg[0];
                    st_d.shreg = {1'b1, st_q.shreg[REST_W-1:1]};
                    st_d.left  = st_q.left - LEN_W'(1);
                end else if (!st_q.empty) begin
                    st_d.txd   = 1'b0;
                    st_d.shreg = frame_rest;
                    st_d.left  = frame_len;
                    st_d.busy  = 1'b1;
                    st_d.empty = 1'b1;
                end else begin
                    st_d.txd   = 1'b1;
                    st_d.busy  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, txd: 1'b1, empty: 1'b1, hold: '0, shreg: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_byte  = st_q.hold;
    assign txd        = st_q.txd;
    assign hold_empty = st_q.empty;

    AST_MRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (txd && hold_empty)); // R10

    AST_LINE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !mrst) |=> $stable(txd)); // R5

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold_empty && !mrst) |=> $stable(hold_byte)); // R8

    AST_EMPTY_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_empty) && !$past(mrst)) |-> !txd); // R7

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> txd); // R1

endmodule

// File: rtl/async_char_tx.sv
`timescale 1ns/1ps
module async_char_tx
    import async_tx_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_tick,
    input  logic [2:0] fmt_sel,
    input  logic [1:0] rate_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rts_on,
    output logic       txd,
    output logic       hold_empty,
    output logic       rts_n
);
    logic              bit_stb;
    logic              mrst;
    logic [WORD_W-1:0] hold_byte;
    logic [REST_W-1:0] frame_rest;
    logic [LEN_W-1:0]  frame_len;

    assign mrst  = (rate_sel == RATE_MRST);
    assign rts_n = ~(rts_on && !mrst);

    tx_bit_timer #(
        .DIV_MID (DIV_MID),
        .DIV_HI  (DIV_HI)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_tick  (tx_tick),
        .rate_sel (rate_sel),
        .bit_stb  (bit_stb)
    );

    tx_frame_build u_build (
        .fmt_code  (fmt_sel),
        .byte_in   (hold_byte),
        .rest_bits (frame_rest),
        .rest_len  (frame_len)
    );

    tx_char_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .mrst       (mrst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .frame_rest (frame_rest),
        .frame_len  (frame_len),
        .hold_byte  (hold_byte),
        .txd        (txd),
        .hold_empty (hold_empty)
    );

    AST_RTS_MRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == RATE_MRST) |-> rts_n); // R11

endmodule

// File: tb/async_char_tx_test.sv
`timescale 1ns/1ps
module async_char_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_tick = 1'b1;
    logic [2:0] fmt_sel = 3'b101;
    logic [1:0] rate_sel = 2'b01;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rts_on = 1'b0;
    logic       txd, hold_empty, rts_n;

    int  n_chk = 0;
    int  n_err = 0;
    bit  sparse_tick = 1'b0;
    bit  tick_hold = 1'b0;
    int  phase = 0;

    always #4 clk = ~clk;

    async_char_tx uut (
        .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .fmt_sel(fmt_sel),
        .rate_sel(rate_sel), .wr_en(wr_en), .wr_data(wr_data), .rts_on(rts_on),
        .txd(txd), .hold_empty(hold_empty), .rts_n(rts_n)
    );

    always @(negedge clk) begin
        phase   = (phase == 2) ? 0 : phase + 1;
        tx_tick = tick_hold ? 1'b0 : (sparse_tick ? (phase == 0) : 1'b1);
    end

    // {fmt, data, rate}
    localparam logic [12:0] VEC [10] = '{
        {3'b000, 8'h41, 2'b01}, {3'b001, 8'h41, 2'b01}, {3'b010, 8'hC1, 2'b01},
        {3'b011, 8'h80, 2'b01}, {3'b100, 8'hA5, 2'b01}, {3'b101, 8'h5A, 2'b00},
        {3'b110, 8'h96, 2'b01}, {3'b111, 8'h96, 2'b00}, {3'b111, 8'h00, 2'b01},
        {3'b000, 8'hFF, 2'b00}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic void exp_frame(input logic [2:0] f, input logic [7:0] d,
                                      output logic [11:0] b, output int len);
        int nd;
        int ns;
        bit pe;
        bit ones;
        nd   = f[2] ? 8 : 7;
        pe   = !(f == 3'b100 || f == 3'b101);
        ns   = (f == 3'b000 || f == 3'b001 || f == 3'b100) ? 2 : 1;
        ones = 1'b0;
        b    = '1;
        b[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            b[1+i] = d[i];
            ones   = ones ^ d[i];
        end
        if (pe) b[1+nd] = ones ^ f[0];
        len = 1 + nd + (pe ? 1 : 0) + ns;
    endfunction

    task automatic put_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_start(output bit found);
        found = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (txd == 1'b0) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    task automatic get_frame(input int per, input int len, input bit in_start, output logic [11:0] bits);
        bit found;
        bits = '1;
        found = in_start;
        if (!in_start) wait_start(found);
        if (found) begin
            repeat (in_start ? 0 : per / 2) @(negedge clk);
            bits[0] = txd;
            for (int i = 1; i < len; i++) begin
                repeat (per) @(negedge clk);
                bits[i] = txd;
            end
        end
    endtask

    task automatic measure_start(output int cnt);
        bit found;
        cnt = 0;
        wait_start(found);
        if (found) begin
            cnt = 1;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (txd != 1'b0) break;
                cnt++;
            end
        end
    endtask

    task automatic quiet_for(input int cycles, output bit stayed_high);
        stayed_high = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd != 1'b1) stayed_high = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [11:0] got, exp, exp2;
        int len, len2, per, cnt;
        bit quiet;

        // reset state R1 R6 R11
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R1 reset idle", txd, 1);
        check(hold_empty == 1'b1, "R6 reset empty", hold_empty, 1);
        check(rts_n == 1'b1, "R11 rts off", rts_n, 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R1 R2 R3 R4
        for (int v = 0; v < 10; v++) begin
            fmt_sel  = VEC[v][12:10];
            rate_sel = VEC[v][1:0];
            per      = (VEC[v][1:0] == 2'b00) ? 1 : 16;
            exp_frame(VEC[v][12:10], VEC[v][9:2], exp, len);
            put_byte(VEC[v][9:2]);
            get_frame(per, len, 1'b0, got);
            check(got == exp, "R1/R2/R3/R4 frame", {20'd0, got}, {20'd0, exp});
            repeat (per * 3) @(negedge clk);
        end

        // R4: bit 7 ignored in a 7-bit format
        fmt_sel = 3'b011; rate_sel = 2'b00;
        exp_frame(3'b011, 8'h35, exp, len);
        put_byte(8'hB5);
        get_frame(1, len, 1'b0, got);
        check(got == exp, "R4 bit7 dropped", {20'd0, got}, {20'd0, exp});
        repeat (4) @(negedge clk);

        // R5: bit time per ratio
        fmt_sel = 3'b101;
        rate_sel = 2'b00; put_byte(8'h01); measure_start(cnt);
        check(cnt == 1, "R5 ratio 1", cnt, 1);
        repeat (20) @(negedge clk);
        rate_sel = 2'b01; put_byte(8'h01); measure_start(cnt);
        check(cnt == 16, "R5 ratio 16", cnt, 16);
        repeat (200) @(negedge clk);
        rate_sel = 2'b10; put_byte(8'h01); measure_start(cnt);
        check(cnt == 64, "R5 ratio 64", cnt, 64);
        repeat (700) @(negedge clk);
        sparse_tick = 1'b1;
        rate_sel = 2'b01; put_byte(8'h01); measure_start(cnt);
        check(cnt == 48, "R5 counts ticks", cnt, 48);
        repeat (600) @(negedge clk);
        sparse_tick = 1'b0;

        // R6 R8: write to full buffer ignored
        tick_hold = 1'b1;
        repeat (2) @(negedge clk);
        fmt_sel = 3'b101; rate_sel = 2'b01;
        put_byte(8'h3C);
        check(hold_empty == 1'b0, "R6 empty cleared", hold_empty, 0);
        put_byte(8'hFF);
        check(hold_empty == 1'b0, "R8 flag stays 0", hold_empty, 0);
        tick_hold = 1'b0;
        exp_frame(3'b101, 8'h3C, exp, len);
        get_frame(16, len, 1'b0, got);
        check(got == exp, "R8 first byte kept", {20'd0, got}, {20'd0, exp});
        quiet_for(300, quiet);
        check(quiet, "R8 second byte dropped", quiet, 1);
        check(hold_empty == 1'b1, "R7 empty after load", hold_empty, 1);

        // R7 R9: back-to-back characters
        fmt_sel = 3'b110; rate_sel = 2'b01;
        put_byte(8'hA3);
        for (int i = 0; i < 40 && !hold_empty; i++) @(negedge clk);
        check(hold_empty == 1'b1 && txd == 1'b0, "R7 empty at start bit", {hold_empty, txd}, 2'b10);
        put_byte(8'h5C);
        exp_frame(3'b110, 8'hA3, exp, len);
        exp_frame(3'b110, 8'h5C, exp2, len2);
        got = '1;
        got[0] = 1'b0;
        for (int i = 1; i < len; i++) begin
            repeat (16) @(negedge clk);
            got[i] = txd;
        end
        check(got == exp, "R9 first of pair", {20'd0, got}, {20'd0, exp});
        repeat (16) @(negedge clk);
        get_frame(16, len2, 1'b1, got);
        check(got == exp2, "R9 second follows directly", {20'd0, got}, {20'd0, exp2});
        repeat (64) @(negedge clk);

        // R10 R11: master reset mid-frame
        rts_on = 1'b1;
        @(negedge clk);
        check(rts_n == 1'b0, "R11 rts asserted", rts_n, 0);
        fmt_sel = 3'b101; rate_sel = 2'b01;
        put_byte(8'h00);
        wait_start(quiet);
        repeat (40) @(negedge clk);
        put_byte(8'h0F);
        rate_sel = 2'b11;
        @(negedge clk);
        check(txd == 1'b1 && hold_empty == 1'b1, "R10 line idle and empty", {txd, hold_empty}, 2'b11);
        check(rts_n == 1'b1, "R11 rts forced off", rts_n, 1);
        put_byte(8'h55);
        check(hold_empty == 1'b1, "R10 write ignored", hold_empty, 1);
        repeat (3) @(negedge clk);
        rate_sel = 2'b01;
        quiet_for(400, quiet);
        check(quiet, "R10 pending dropped", quiet, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule